// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port

This block pairs an asynchronous serial transmitter with a receiver under one 8-bit control register. The register holds four controls: an internal loop-back path, the enable for the whole port and its baud generator, an inversion of every level driven on the transmit line, and the choice between 8-bit and 9-bit characters. A frame is one start bit, the data bits least significant first, and one stop bit. In 9-bit mode the extra bit comes from a separate input.

The bit rate comes from a divisor input. A tick pulse fires once every `baud_div` clocks while the port is enabled, and one bit lasts sixteen ticks. The transmitter has a holding register in front of its shifter, so software can queue a second character while the first is still on the line. Two flags report the state of this path: one says the holding register is free, the other says the line has gone quiet. The receiver samples each bit at its middle. It rejects a start pulse that has gone high again by mid-bit, and it flags a frame whose stop bit reads low.

Top module: `serial_port_top`

## Requirements
- R1: After reset the control register reads 0, `txd` is high, `tx_empty` and `tx_done` are 1, and `rx_full` is 0.
- R2: The control register bits are: bit 7 loop-back, bit 6 enable, bit 5 transmit inversion, bit 4 nine-bit mode. Writes to bits 3..0 have no effect, and those bits read as 0.
- R3: In 8-bit mode the transmitter drives a low start bit, then data bits 0 to 7 in that order, then a high stop bit. Each bit lasts 16×`baud_div` clocks.
- R4: In 9-bit mode the frame carries `tx_wbit8` as a ninth data bit, sent after data bit 7 and before the stop bit.
- R5: With inversion set, every level on `txd` is the complement of the normal level: idle, start, data and stop. The idle line is therefore low.
- R6: A write clears `tx_empty` until the character moves into the shifter. `tx_done` is 0 while a frame is shifting or a character is pending, and it returns to 1 once the line is idle with nothing queued.
- R7: While the enable bit is clear, `tx_empty` and `tx_done` are 1, transmit writes are discarded, and `txd` rests at the idle level.
- R8: A received frame sets `rx_full` and presents its data on `rx_data`, plus the ninth bit on `rx_bit8` in 9-bit mode. `rx_ack` clears `rx_full`.
- R9: A frame whose stop bit samples low is delivered with `rx_ferr` set. After such a frame, the receiver does not treat the still-low line as a new start.
- R10: A low pulse on the receive line that returns high before mid-bit produces no character.
- R11: In loop mode the receiver takes its input from `txd`, and the `rxd` pin has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write value |
| ctrl_rdata | output | 8 | Control register read value |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| baud_div | input | DIV_W | Clocks per baud tick |
| tx_we | input | 1 | Transmit data write strobe |
| tx_wdata | input | 8 | Transmit data bits 7..0 |
| tx_wbit8 | input | 1 | Ninth transmit bit |
| tx_empty | output | 1 | Transmit holding register free |
| tx_done | output | 1 | Line idle and nothing pending |
| rx_ack | input | 1 | Clears the receive-full flag |
| rx_data | output | 8 | Received data bits 7..0 |
| rx_bit8 | output | 1 | Received ninth bit |
| rx_full | output | 1 | A received character is waiting |
| rx_ferr | output | 1 | The last character had a low stop bit |
| rxd | input | 1 | Serial receive pin |
| txd | output | 1 | Serial transmit pin |

## Verification
The transmitter is tested with the bytes 0xA5 and 0x3C sent back to back, which exposes bit-order errors and a broken holding register. A 9-bit character with its top bit set and an inverted 0x81 separate the ninth-bit path and the polarity path from the plain 8-bit path. The receiver gets a normal byte, a 9-bit character, a frame with a low stop bit and a short glitch, which separate correct delivery from framing detection and from start rejection. A loop-back run with the pin held low shows the internal path is used and the pin has no effect.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;

    localparam int OVERSAMPLE = 16;
    localparam int SUB_W      = $clog2(OVERSAMPLE);
    localparam int MAX_BITS   = 9;
    localparam int IDX_W      = $clog2(MAX_BITS + 1);

    localparam int BIT_LOOP   = 7;
    localparam int BIT_ENABLE = 6;
    localparam int BIT_INVERT = 5;
    localparam int BIT_NINE   = 4;

    typedef struct packed {
        logic loop;
        logic enable;
        logic invert;
        logic nine;
    } ctrl_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_STOP
    } phase_e;

    function automatic ctrl_t decode_ctrl(input logic [7:0] w);
        ctrl_t c;
        c.loop   = w[BIT_LOOP];
        c.enable = w[BIT_ENABLE];
        c.invert = w[BIT_INVERT];
        c.nine   = w[BIT_NINE];
        return c;
    endfunction

    function automatic logic [7:0] encode_ctrl(input ctrl_t c);
        logic [7:0] w;
        w             = '0;
        w[BIT_LOOP]   = c.loop;
        w[BIT_ENABLE] = c.enable;
        w[BIT_INVERT] = c.invert;
        w[BIT_NINE]   = c.nine;
        return w;
    endfunction

    function automatic logic [IDX_W-1:0] last_index(input logic nine);
        return nine ? IDX_W'(MAX_BITS - 1) : IDX_W'(MAX_BITS - 2);
    endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int EXT_W = DIV_W + 1;

    logic [DIV_W-1:0] cnt;
    logic [EXT_W-1:0] next_cnt;

    assign next_cnt = {1'b0, cnt} + EXT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (next_cnt >= {1'b0, div}) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= next_cnt[DIV_W-1:0];
            tick <= 1'b0;
        end
    end

    p_tick_stops_r7: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tick);

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
    import uart_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       tx_en,
    input  logic       tick,
    input  logic       invert,
    input  logic       nine,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       wbit8,
    output logic       txd,
    output logic       tx_empty,
    output logic       tx_done
);
    phase_e               ph;
    logic [MAX_BITS-1:0]  hold_data;
    logic                 hold_full;
    logic [MAX_BITS-1:0]  sh;
    logic [IDX_W-1:0]     idx;
    logic [IDX_W-1:0]     last;
    logic [SUB_W-1:0]     sub;
    logic                 raw;

    always_comb begin
        unique case (ph)
            PH_START: raw = 1'b0;
            PH_DATA:  raw = sh[0];
            default:  raw = 1'b1;
        endcase
    end

    assign txd      = raw ^ invert;
    assign tx_empty = !hold_full;
    assign tx_done  = (ph == PH_IDLE) && !hold_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            hold_data <= '0;
            hold_full <= 1'b0;
            sh        <= '0;
            idx       <= '0;
            last      <= '0;
            sub       <= '0;
        end else if (!enable) begin
            ph        <= PH_IDLE;
            hold_full <= 1'b0;
            sub       <= '0;
        end else begin
            if (ph == PH_IDLE) begin
                if (hold_full && tx_en) begin
                    sh        <= hold_data;
                    last      <= last_index(nine);
                    ph        <= PH_START;
                    sub       <= '0;
                    hold_full <= 1'b0;
                end
            end else if (tick) begin
                sub <= sub + SUB_W'(1);
                if (sub == SUB_W'(OVERSAMPLE - 1)) begin
                    unique case (ph)
                        PH_START: begin
                            ph  <= PH_DATA;
                            idx <= '0;
                        end
                        PH_DATA: begin
                            sh <= sh >> 1;
                            if (idx == last) ph <= PH_STOP;
                            else             idx <= idx + IDX_W'(1);
                        end
                        default: ph <= PH_IDLE;
                    endcase
                end
            end
            if (wr) begin
                hold_data <= {wbit8, wdata};
                hold_full <= 1'b1;
            end
        end
    end

    p_write_fills_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && enable) |=> !tx_empty);

    p_stop_then_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (enable && ph == PH_STOP && tick && sub == SUB_W'(OVERSAMPLE - 1))
        |=> (ph == PH_IDLE));

endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
    import uart_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tick,
    input  logic       nine,
    input  logic       line_in,
    input  logic       ack,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       rx_full,
    output logic       rx_ferr
);
    logic                s1, s2, s3;
    phase_e              ph;
    logic [SUB_W-1:0]    sub;
    logic [IDX_W-1:0]    idx;
    logic [MAX_BITS-1:0] sh;
    logic                bit_end;

    assign bit_end = tick && (sub == SUB_W'(OVERSAMPLE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= line_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            sub     <= '0;
            idx     <= '0;
            sh      <= '0;
            rx_data <= '0;
            rx_bit8 <= 1'b0;
            rx_full <= 1'b0;
            rx_ferr <= 1'b0;
        end else begin
            if (ack) rx_full <= 1'b0;
            if (!run) begin
                ph  <= PH_IDLE;
                sub <= '0;
            end else begin
                unique case (ph)
                    PH_IDLE: begin
                        if (s3 && !s2) begin
                            ph  <= PH_START;
                            sub <= '0;
                        end
                    end
                    PH_START: begin
                        if (tick) begin
                            if (sub == SUB_W'(OVERSAMPLE / 2 - 1)) begin
                                sub <= '0;
                                idx <= '0;
                                ph  <= s2 ? PH_IDLE : PH_DATA;
                            end else begin
                                sub <= sub + SUB_W'(1);
                            end
                        end
                    end
                    PH_DATA: begin
                        if (tick) sub <= sub + SUB_W'(1);
                        if (bit_end) begin
                            sh <= {s2, sh[MAX_BITS-1:1]};
                            if (idx == last_index(nine)) ph <= PH_STOP;
                            else                         idx <= idx + IDX_W'(1);
                        end
                    end
                    default: begin
                        if (tick) sub <= sub + SUB_W'(1);
                        if (bit_end) begin
                            ph      <= PH_IDLE;
                            rx_full <= 1'b1;
                            rx_ferr <= !s2;
                            rx_data <= nine ? sh[7:0] : sh[8:1];
                            rx_bit8 <= nine ? sh[8] : 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    p_full_from_stop_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> $past(ph == PH_STOP));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (ack && !(run && ph == PH_STOP && bit_end)) |=> !rx_full);

endmodule

// File: rtl/serial_port_top.sv
module serial_port_top
    import uart_cfg_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_wdata,
    output logic [7:0]       ctrl_rdata,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             tx_we,
    input  logic [7:0]       tx_wdata,
    input  logic             tx_wbit8,
    output logic             tx_empty,
    output logic             tx_done,
    input  logic             rx_ack,
    output logic [7:0]       rx_data,
    output logic             rx_bit8,
    output logic             rx_full,
    output logic             rx_ferr,
    input  logic             rxd,
    output logic             txd
);
    ctrl_t ctrl;
    logic  tick;
    logic  rx_line;

    always_ff @(posedge clk) begin
        if (rst)          ctrl <= '0;
        else if (ctrl_we) ctrl <= decode_ctrl(ctrl_wdata);
    end

    assign ctrl_rdata = encode_ctrl(ctrl);
    assign rx_line    = ctrl.loop ? txd : rxd;

    uart_baud_gen #(.DIV_W(DIV_W)) baud_i (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl.enable),
        .div  (baud_div),
        .tick (tick)
    );

    uart_tx_path tx_i (
        .clk      (clk),
        .rst      (rst),
        .enable   (ctrl.enable),
        .tx_en    (tx_en),
        .tick     (tick),
        .invert   (ctrl.invert),
        .nine     (ctrl.nine),
        .wr       (tx_we),
        .wdata    (tx_wdata),
        .wbit8    (tx_wbit8),
        .txd      (txd),
        .tx_empty (tx_empty),
        .tx_done  (tx_done)
    );

    uart_rx_path rx_i (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.enable && rx_en),
        .tick    (tick),
        .nine    (ctrl.nine),
        .line_in (rx_line),
        .ack     (rx_ack),
        .rx_data (rx_data),
        .rx_bit8 (rx_bit8),
        .rx_full (rx_full),
        .rx_ferr (rx_ferr)
    );

    p_off_flags_r7: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |=> (tx_empty && tx_done));

    p_idle_level_r5: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (txd == !ctrl.invert));

    p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> (ctrl_rdata[3:0] == 4'h0));

endmodule

// File: tb/serial_port_top_tb_top.sv
`timescale 1ns/1ps
module serial_port_top_tb_top;

    localparam int DIV = 2;
    localparam int BIT = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic [11:0] baud_div = 12'(DIV);
    logic       tx_we = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic       tx_wbit8 = 1'b0;
    logic       tx_empty, tx_done;
    logic       rx_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit8, rx_full, rx_ferr;
    logic       rxd = 1'b1;
    logic       txd;

    always #2.5 clk = ~clk;

    serial_port_top dut_i (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .tx_en(tx_en), .rx_en(rx_en),
        .baud_div(baud_div), .tx_we(tx_we), .tx_wdata(tx_wdata),
        .tx_wbit8(tx_wbit8), .tx_empty(tx_empty), .tx_done(tx_done),
        .rx_ack(rx_ack), .rx_data(rx_data), .rx_bit8(rx_bit8),
        .rx_full(rx_full), .rx_ferr(rx_ferr), .rxd(rxd), .txd(txd)
    );

    typedef struct {
        logic [7:0] d;
        logic       b8;
        logic       fe;
        string      req;
    } rx_item_t;

    rx_item_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    int rx_seen = 0;
    bit done_flag = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_tx(input logic [7:0] d, input logic b8);
        @(negedge clk); tx_we = 1'b1; tx_wdata = d; tx_wbit8 = b8;
        @(negedge clk); tx_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Decodes one frame from txd, undoing inversion when inv is set.
    task automatic grab_tx(input int nbits, input logic inv, input string req,
                           output logic [8:0] val, output logic stopv);
        int waited = 0;
        val = '0;
        stopv = 1'b0;
        while ((txd ^ inv) == 1'b1 && waited < 40 * BIT) begin
            @(negedge clk);
            waited++;
        end
        check(waited < 40 * BIT, req, "start bit seen", waited, 0);
        idle(BIT / 2);
        check((txd ^ inv) == 1'b0, req, "start bit low at mid", int'(txd ^ inv), 0);
        for (int i = 0; i < nbits; i++) begin
            idle(BIT);
            val[i] = txd ^ inv;
        end
        idle(BIT);
        stopv = txd ^ inv;
    endtask

    task automatic drive_rx(input logic [8:0] val, input int nbits, input logic stopv);
        rxd = 1'b0;
        idle(BIT);
        for (int i = 0; i < nbits; i++) begin
            rxd = val[i];
            idle(BIT);
        end
        rxd = stopv;
        idle(BIT);
        rxd = 1'b1;
        idle(BIT);
    endtask

    // Scoreboard monitor: pops the expected item whenever a character arrives.
    initial begin
        forever begin
            @(negedge clk);
            if (rx_ack) begin
                rx_ack = 1'b0;
            end else if (rx_full) begin
                rx_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected character", int'(rx_data), 0);
                end else begin
                    rx_item_t e;
                    e = exp_q.pop_front();
                    check(rx_data == e.d, e.req, "rx_data", int'(rx_data), int'(e.d));
                    check(rx_bit8 == e.b8, e.req, "rx_bit8", int'(rx_bit8), int'(e.b8));
                    check(rx_ferr == e.fe, e.req, "rx_ferr", int'(rx_ferr), int'(e.fe));
                end
                rx_ack = 1'b1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        logic [8:0] v;
        logic       s;
        int         seen0;
        rx_item_t   it;

        idle(3);
        rst = 1'b0;
        idle(2);
        // R1 reset state
        check(ctrl_rdata == 8'h00, "R1", "ctrl after reset", int'(ctrl_rdata), 0);
        check(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
        check(tx_empty && tx_done, "R1", "tx flags after reset", int'({tx_empty, tx_done}), 3);
        check(rx_full == 1'b0, "R1", "rx_full after reset", int'(rx_full), 0);

        // R7 disabled: transmit write discarded
        tx_en = 1'b1;
        rx_en = 1'b1;
        wr_tx(8'h55, 1'b0);
        idle(3 * BIT);
        check(tx_empty && tx_done, "R7", "flags with port off", int'({tx_empty, tx_done}), 3);
        check(txd == 1'b1, "R7", "txd idle with port off", int'(txd), 1);

        // R2 field positions, low nibble ignored
        wr_ctrl(8'h5F);
        check(ctrl_rdata == 8'h50, "R2", "ctrl readback", int'(ctrl_rdata), 8'h50);
        wr_ctrl(8'h40);
        check(ctrl_rdata == 8'h40, "R2", "ctrl enable only", int'(ctrl_rdata), 8'h40);

        // R3/R6 back-to-back 8-bit frames
        wr_tx(8'hA5, 1'b0);
        wr_tx(8'h3C, 1'b0);
        idle(2);
        check(tx_empty == 1'b0, "R6", "second char pending", int'(tx_empty), 0);
        check(tx_done == 1'b0, "R6", "tx_done while busy", int'(tx_done), 0);
        grab_tx(8, 1'b0, "R3", v, s);
        check(v[7:0] == 8'hA5, "R3", "first frame data", int'(v[7:0]), 8'hA5);
        check(s == 1'b1, "R3", "first stop bit", int'(s), 1);
        grab_tx(8, 1'b0, "R3", v, s);
        check(v[7:0] == 8'h3C, "R3", "second frame data", int'(v[7:0]), 8'h3C);
        check(s == 1'b1, "R3", "second stop bit", int'(s), 1);
        idle(BIT);
        check(tx_empty && tx_done, "R6", "flags after frames", int'({tx_empty, tx_done}), 3);

        // R4 nine-bit transmit
        wr_ctrl(8'h50);
        wr_tx(8'h0F, 1'b1);
        grab_tx(9, 1'b0, "R4", v, s);
        check(v == 9'h10F, "R4", "nine-bit frame", int'(v), 9'h10F);
        check(s == 1'b1, "R4", "nine-bit stop", int'(s), 1);
        idle(BIT);

        // R5 inverted line
        wr_ctrl(8'h60);
        idle(2);
        check(txd == 1'b0, "R5", "inverted idle", int'(txd), 0);
        wr_tx(8'h81, 1'b0);
        grab_tx(8, 1'b1, "R5", v, s);
        check(v[7:0] == 8'h81, "R5", "inverted frame data", int'(v[7:0]), 8'h81);
        check(s == 1'b1, "R5", "inverted stop", int'(s), 1);
        idle(BIT);
        check(txd == 1'b0, "R5", "inverted idle after frame", int'(txd), 0);

        // R8 receive 8-bit and 9-bit
        wr_ctrl(8'h40);
        it = '{d: 8'h5A, b8: 1'b0, fe: 1'b0, req: "R8"};
        exp_q.push_back(it);
        drive_rx(9'h05A, 8, 1'b1);
        wr_ctrl(8'h50);
        it = '{d: 8'hC3, b8: 1'b1, fe: 1'b0, req: "R8"};
        exp_q.push_back(it);
        drive_rx(9'h1C3, 9, 1'b1);

        // R9 framing error
        wr_ctrl(8'h40);
        it = '{d: 8'h99, b8: 1'b0, fe: 1'b1, req: "R9"};
        exp_q.push_back(it);
        drive_rx(9'h099, 8, 1'b0);
        idle(2 * BIT);
        check(exp_q.size() == 0, "R9", "framing frame delivered", exp_q.size(), 0);

        // R10 glitch rejection
        seen0 = rx_seen;
        rxd = 1'b0;
        idle(BIT / 4);
        rxd = 1'b1;
        idle(12 * BIT);
        check(rx_seen == seen0, "R10", "glitch produced no char", rx_seen - seen0, 0);
        it = '{d: 8'h24, b8: 1'b0, fe: 1'b0, req: "R10"};
        exp_q.push_back(it);
        drive_rx(9'h024, 8, 1'b1);

        // R11 loop-back with pin held low
        wr_ctrl(8'hC0);
        rxd = 1'b0;
        seen0 = rx_seen;
        it = '{d: 8'h96, b8: 1'b0, fe: 1'b0, req: "R11"};
        exp_q.push_back(it);
        wr_tx(8'h96, 1'b0);
        idle(13 * BIT);
        check(rx_seen == seen0 + 1, "R11", "loop char received", rx_seen - seen0, 1);
        rxd = 1'b1;
        idle(4);

        // R7 disabling sets flags
        wr_ctrl(8'h40);
        wr_tx(8'h11, 1'b0);
        idle(BIT);
        wr_ctrl(8'h00);
        idle(2);
        check(tx_empty && tx_done, "R7", "flags after disable", int'({tx_empty, tx_done}), 3);
        check(txd == 1'b1, "R7", "txd after disable", int'(txd), 1);

        idle(4);
        check(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 0);
        report();
    end

endmodule